// File: doc/BRIEF.md
# Two-Byte Command Register Loader

This block sits behind a serial byte receiver and turns its byte stream into register writes. Each command is two bytes: an opcode, then one data byte. The opcode chooses the target. It can be the duty byte of one PWM channel, or one of five configuration bytes that drive the modulation logic: a prescaler, two arithmetic operands, a phase seed and a shift-register seed. The data byte is the value written. All registers are exported in parallel to the PWM array and the modulation logic next to this block.

Bytes arrive already assembled, as an 8-bit value and a one-cycle valid strobe. An enable input gates all command traffic. A synchronous clear input, separate from reset, returns every register and the sequencer to their starting state. Opcodes `0x80`+n (n from 0 to 55) select PWM duty channel n. Opcodes `0xC0` to `0xC4` select the configuration bytes. Any other byte that arrives while an opcode is expected is discarded.

Top module: `cmd_reg_loader`

## Requirements
- R1: While `rst_n` is 0 at a rising clock edge, every duty byte and every configuration byte becomes 0x00 and the sequencer returns to expecting an opcode. A byte accepted after reset is therefore taken as an opcode, even if an opcode was pending before reset.
- R2: The byte 0x80+n, for n in 0..55, followed by a data byte D, sets duty channel n (bits 8n+7..8n of `duty_flat`) to D. No other register changes.
- R3: Opcodes 0xC0, 0xC1, 0xC2, 0xC3 and 0xC4, each followed by D, set `prescale`, `alu_a`, `alu_b`, `phase_seed` and `lfsr_seed` to D, in that order.
- R4: The byte that follows an accepted opcode is taken as data whatever its value, including values in the opcode ranges. After that write the sequencer expects an opcode again.
- R5: While an opcode is expected, the bytes 0x00–0x7F, 0xB8–0xBF and 0xC5–0xFF change no register and do not start a command. The next byte is still treated as an opcode.
- R6: A byte presented while `cmd_en` is 0 changes no register and is not taken as an opcode.
- R7: If `cmd_en` is 0 in any cycle between an accepted opcode and its data byte, the pending opcode is dropped. The next accepted byte is treated as an opcode.
- R8: A cycle with `clr` at 1 sets all duty and configuration bytes to 0x00 and returns the sequencer to expecting an opcode. This overrides a data byte that arrives in the same cycle.
- R9: A write takes effect at the clock edge where the data byte's `rx_valid` is sampled, and is visible on the outputs after that edge. Cycles with `rx_valid` at 0 are ignored, whatever `rx_data` holds, and do not end a pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of all registers and of the sequencer |
| cmd_en | input | 1 | Command enable; 0 ignores bytes and drops a pending opcode |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_data | input | 8 | Received byte |
| duty_flat | output | 448 | Duty bytes for channels 0..55, channel n in bits 8n+7..8n |
| prescale | output | 8 | Prescaler byte |
| alu_a | output | 8 | First arithmetic operand |
| alu_b | output | 8 | Second arithmetic operand |
| phase_seed | output | 8 | Phase accumulator seed |
| lfsr_seed | output | 8 | Shift-register seed |

## Verification
The hard cases are the ones where the sequencer sits with an opcode pending and something other than a clean data byte comes next. Examples are a data value that looks like an opcode, enable dropping for one cycle with no byte present, a clear or reset landing on the data cycle, and long gaps with `rx_valid` low. From the ports these can only be seen through which register changes on a later byte. The stimulus therefore follows each such disturbance with a probe byte whose value would write a register if the sequencer were in the wrong state. After every byte the whole register image is compared against a model.

// File: rtl/cmd_reg_loader_pkg.sv
// Package: shared constants and types for the two-byte command loader.
// Assumes bytes are 8 bits and that both opcode bases are 64-aligned, so
// the low six bits of an opcode are the target index.
package cmd_reg_loader_pkg;

    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 6;
    localparam int NUM_CFG   = 5;

    localparam logic [BYTE_W-1:0] OP_DUTY_BASE = 8'h80;
    localparam logic [BYTE_W-1:0] OP_CFG_BASE  = 8'hC0;

    // Configuration byte slots, in opcode order
    localparam int CFG_PRESCALE = 0;
    localparam int CFG_ALU_A    = 1;
    localparam int CFG_ALU_B    = 2;
    localparam int CFG_PHASE    = 3;
    localparam int CFG_LFSR     = 4;

    typedef enum logic {
        ST_OPCODE = 1'b0,
        ST_DATA   = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cmd_seq.sv
// Module: cmd_seq
// Sequences the byte stream into opcode/data pairs and issues one write
// strobe when the data byte arrives. Assumes rx_valid marks one byte per
// cycle. Opcodes outside the duty and configuration ranges are dropped.
module cmd_seq
    import cmd_reg_loader_pkg::*;
#(
    parameter int NUM_CH = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cmd_en,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              duty_we,
    output logic              cfg_we,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [BYTE_W:0] DUTY_END = (BYTE_W+1)'({1'b0, OP_DUTY_BASE} + (BYTE_W+1)'(NUM_CH));
    localparam logic [BYTE_W:0] CFG_END  = (BYTE_W+1)'({1'b0, OP_CFG_BASE} + (BYTE_W+1)'(NUM_CFG));

    seq_state_e       state_q;
    logic             pend_duty_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             is_duty_op;
    logic             is_cfg_op;
    logic             take;
    logic             fire;

    // Classify the incoming byte against both opcode ranges
    always_comb begin
        is_duty_op = ({1'b0, rx_data} >= {1'b0, OP_DUTY_BASE}) && ({1'b0, rx_data} < DUTY_END);
        is_cfg_op  = ({1'b0, rx_data} >= {1'b0, OP_CFG_BASE})  && ({1'b0, rx_data} < CFG_END);
        take       = rx_valid && cmd_en;
        fire       = (state_q == ST_DATA) && take && !clr;
    end

    // Track opcode/data phase and remember the pending target
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q     <= ST_OPCODE;
            pend_duty_q <= 1'b0;
            pend_idx_q  <= '0;
        end else begin
            case (state_q)
                ST_OPCODE: begin
                    if (take && (is_duty_op || is_cfg_op)) begin
                        state_q     <= ST_DATA;
                        pend_duty_q <= is_duty_op;
                        pend_idx_q  <= rx_data[IDX_W-1:0];
                    end
                end
                default: begin
                    if (!cmd_en || rx_valid) begin
                        state_q <= ST_OPCODE;
                    end
                end
            endcase
        end
    end

    // Route the data byte to the selected bank
    always_comb begin
        duty_we = fire && pend_duty_q;
        cfg_we  = fire && !pend_duty_q;
        wr_idx  = pend_idx_q;
        wr_data = rx_data;
    end

    p_data_ends_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && rx_valid && cmd_en) |=> (state_q == ST_OPCODE));

    p_disable_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !cmd_en) |=> (state_q == ST_OPCODE));

    p_clr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_OPCODE && !duty_we && !cfg_we));

    p_bad_op_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE && !is_duty_op && !is_cfg_op) |=> (state_q == ST_OPCODE));

    p_disabled_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE && !cmd_en) |=> (state_q == ST_OPCODE));

endmodule

// File: rtl/duty_bank.sv
// Module: duty_bank
// Holds one duty byte per PWM channel and loads the addressed byte on a
// write strobe. Assumes wr_idx is below NUM_CH whenever we is high.
module duty_bank
    import cmd_reg_loader_pkg::*;
#(
    parameter int NUM_CH = 56
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NUM_CH*BYTE_W-1:0] duty_flat
);

    logic [NUM_CH-1:0] hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [BYTE_W-1:0] duty_q;

        // Decode this channel's write select
        assign hit[g] = we && (wr_idx == IDX_W'(g));

        // Load this channel's duty byte
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                duty_q <= '0;
            end else if (hit[g]) begin
                duty_q <= wr_data;
            end
        end

        assign duty_flat[g*BYTE_W +: BYTE_W] = duty_q;
    end

    p_single_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (duty_flat[$past(wr_idx)*BYTE_W +: BYTE_W] == $past(wr_data)));

endmodule

// File: rtl/cfg_bank.sv
// Module: cfg_bank
// Holds the configuration bytes for the modulation logic and loads the
// selected one on a write strobe. Assumes wr_sel is below NUM_CFG.
module cfg_bank
    import cmd_reg_loader_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          we,
    input  logic [2:0]                    wr_sel,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_q
);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        // Load this configuration byte when selected
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cfg_q[g] <= '0;
            end else if (we && (wr_sel == 3'(g))) begin
                cfg_q[g] <= wr_data;
            end
        end
    end

    p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(cfg_q));

endmodule

// File: rtl/cmd_reg_loader.sv
// Module: cmd_reg_loader (top)
// Turns opcode/data byte pairs into writes to the PWM duty bytes and the
// five modulation configuration bytes. Assumes pre-assembled bytes with a
// one-cycle valid strobe; reset is synchronous and active low.
module cmd_reg_loader
    import cmd_reg_loader_pkg::*;
#(
    parameter int NUM_CH = 56
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     cmd_en,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_data,
    output logic [NUM_CH*8-1:0]      duty_flat,
    output logic [7:0]               prescale,
    output logic [7:0]               alu_a,
    output logic [7:0]               alu_b,
    output logic [7:0]               phase_seed,
    output logic [7:0]               lfsr_seed
);

    logic                          duty_we;
    logic                          cfg_we;
    logic [IDX_W-1:0]              wr_idx;
    logic [BYTE_W-1:0]             wr_data;
    logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_q;

    cmd_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .cmd_en   (cmd_en),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .duty_we  (duty_we),
        .cfg_we   (cfg_we),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    duty_bank #(.NUM_CH(NUM_CH)) u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .we        (duty_we),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .duty_flat (duty_flat)
    );

    cfg_bank u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .we      (cfg_we),
        .wr_sel  (wr_idx[2:0]),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    // Expose configuration slots under their functional names
    always_comb begin
        prescale   = cfg_q[CFG_PRESCALE];
        alu_a      = cfg_q[CFG_ALU_A];
        alu_b      = cfg_q[CFG_ALU_B];
        phase_seed = cfg_q[CFG_PHASE];
        lfsr_seed  = cfg_q[CFG_LFSR];
    end

    p_clr_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (duty_flat == '0 && cfg_q == '0));

    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(duty_we && cfg_we));

    p_idle_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !clr) |=> ($stable(duty_flat) && $stable(cfg_q)));

endmodule

// File: tb/cmd_reg_loader_tb.sv
module cmd_reg_loader_tb;

    localparam int NCH = 56;
    localparam int DW  = NCH * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          cmd_en = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic [DW-1:0] duty_flat;
    logic [7:0]    prescale, alu_a, alu_b, phase_seed, lfsr_seed;

    always #5 clk = ~clk;

    cmd_reg_loader #(.NUM_CH(NCH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .cmd_en     (cmd_en),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .duty_flat  (duty_flat),
        .prescale   (prescale),
        .alu_a      (alu_a),
        .alu_b      (alu_b),
        .phase_seed (phase_seed),
        .lfsr_seed  (lfsr_seed)
    );

    // Reference model state
    logic [DW-1:0] m_duty = '0;
    logic [39:0]   m_cfg  = '0;
    int            m_pend = -1;

    // Scoreboard queues
    logic [DW-1:0] q_duty[$];
    logic [39:0]   q_cfg[$];
    string         q_tag[$];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic push_expect(input string tag);
        q_duty.push_back(m_duty);
        q_cfg.push_back(m_cfg);
        q_tag.push_back(tag);
    endtask

    // Drive one cycle of stimulus and update the model from the requirements
    task automatic cyc(input logic [7:0] b, input bit en, input bit vld,
                       input bit cl, input string tag);
        @(negedge clk);
        rx_data  = b;
        cmd_en   = en;
        rx_valid = vld;
        clr      = cl;
        if (cl) begin
            m_duty = '0;
            m_cfg  = '0;
            m_pend = -1;
        end else if (!en) begin
            m_pend = -1;
        end else if (vld) begin
            if (m_pend >= 0) begin
                if (m_pend < 8'hC0) m_duty[(m_pend - 8'h80)*8 +: 8] = b;
                else                m_cfg[(m_pend - 8'hC0)*8 +: 8]  = b;
                m_pend = -1;
            end else if ((b >= 8'h80 && b <= 8'hB7) || (b >= 8'hC0 && b <= 8'hC4)) begin
                m_pend = int'(b);
            end
        end
        @(posedge clk);
        #1;
        push_expect(tag);
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        cyc(b, 1'b1, 1'b1, 1'b0, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n    = 1'b0;
        rx_valid = 1'b0;
        clr      = 1'b0;
        m_duty   = '0;
        m_cfg    = '0;
        m_pend   = -1;
        @(posedge clk);
        #1;
        push_expect(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare outputs against the oldest expected image
    always @(negedge clk) begin
        if (q_tag.size() > 0) begin
            logic [DW-1:0] ed;
            logic [39:0]   ec;
            logic [39:0]   ac;
            string         t;
            ed = q_duty.pop_front();
            ec = q_cfg.pop_front();
            t  = q_tag.pop_front();
            ac = {lfsr_seed, phase_seed, alu_b, alu_a, prescale};
            total++;
            if (duty_flat !== ed || ac !== ec) begin
                bad++;
                $display("FAIL %s: duty act=%h exp=%h cfg act=%h exp=%h",
                         t, duty_flat, ed, ac, ec);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset("R1 initial reset");
        cyc(8'h00, 1'b1, 1'b0, 1'b0, "R1 idle after reset");

        // R2 duty writes at both ends of the range
        send(8'h80, "R2 op ch0");   send(8'h11, "R2 data ch0");
        send(8'h81, "R2 op ch1");   send(8'h22, "R2 data ch1");
        send(8'h89, "R2 op ch9");   send(8'h99, "R2 data ch9");
        send(8'hB7, "R2 op ch55");  send(8'hA5, "R2 data ch55");
        send(8'hB6, "R2 op ch54");  send(8'h5C, "R2 data ch54");

        // R3 configuration writes
        send(8'hC0, "R3 op prescale"); send(8'h0F, "R3 prescale");
        send(8'hC1, "R3 op alu_a");    send(8'hA1, "R3 alu_a");
        send(8'hC2, "R3 op alu_b");    send(8'hB2, "R3 alu_b");
        send(8'hC3, "R3 op phase");    send(8'hC3, "R3 phase");
        send(8'hC4, "R3 op lfsr");     send(8'hE4, "R3 lfsr");

        // R4 data bytes that look like opcodes
        send(8'h85, "R4 op ch5");  send(8'hC2, "R4 data 0xC2 to ch5");
        send(8'h33, "R4 back to opcode wait");
        send(8'h86, "R4 op ch6");  send(8'h80, "R4 data 0x80 to ch6");
        send(8'h44, "R4 0x44 not data");

        // R5 bytes that must not start a command
        send(8'h12, "R5 low byte"); send(8'h45, "R5 probe");
        send(8'hB8, "R5 0xB8");     send(8'h46, "R5 probe");
        send(8'hBF, "R5 0xBF");     send(8'h47, "R5 probe");
        send(8'hC5, "R5 0xC5");     send(8'h48, "R5 probe");
        send(8'hFF, "R5 0xFF");     send(8'h49, "R5 probe");

        // R6 disabled bytes
        cyc(8'h82, 1'b0, 1'b1, 1'b0, "R6 op while disabled");
        send(8'h55, "R6 probe not data");

        // R7 enable dropped mid-command, with and without a byte
        send(8'h83, "R7 op ch3");
        cyc(8'h00, 1'b0, 1'b0, 1'b0, "R7 disable gap");
        send(8'h77, "R7 probe not data");
        send(8'h83, "R7 op ch3 again");
        cyc(8'h84, 1'b0, 1'b1, 1'b0, "R7 disabled byte");
        send(8'h66, "R7 probe not data");

        // R9 gaps with rx_valid low, junk on rx_data
        send(8'h87, "R9 op ch7");
        cyc(8'h81, 1'b1, 1'b0, 1'b0, "R9 gap 1");
        cyc(8'hC1, 1'b1, 1'b0, 1'b0, "R9 gap 2");
        cyc(8'h13, 1'b1, 1'b0, 1'b0, "R9 gap 3");
        send(8'h5A, "R9 data ch7 after gap");

        // R8 clear overrides a data byte, then leaves decoder idle
        send(8'h88, "R8 op ch8");
        cyc(8'h12, 1'b1, 1'b1, 1'b1, "R8 clear on data cycle");
        send(8'h34, "R8 probe not data");
        send(8'hC0, "R8 op prescale"); send(8'h7E, "R8 prescale after clear");
        cyc(8'h00, 1'b1, 1'b0, 1'b1, "R8 clear while idle");

        // R1 reset with an opcode pending
        send(8'h8A, "R1 op ch10"); send(8'h3C, "R1 data ch10");
        send(8'h8B, "R1 op ch11 pending");
        do_reset("R1 reset mid-command");
        send(8'h21, "R1 probe not data");
        send(8'h8B, "R1 op ch11"); send(8'h6D, "R1 data ch11");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule